// File: doc/BRIEF.md
# Predicated Vector Leading-Zero Counter

This unit takes a 128-bit source vector and splits it into lanes of 8, 16 or 32 bits, as a 2-bit size code selects. It counts the leading zeros in each lane and writes each count, zero-extended, back into the same lane position. The count covers only the bits of the lane itself.

The result is merged into an old destination vector one byte at a time. A 16-bit predicate has one bit for every byte position, whatever the lane size. A byte whose predicate bit is set takes the matching byte of the count result. A byte whose bit is clear keeps its old destination value. A lane wider than a byte can therefore be only partly written.

The unit registers its output, so a result appears one clock after its operands. Size code 3 is not a valid operation. It raises an illegal-size flag and returns the old destination unchanged.

Top module: `vlz_pred_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dst_o` is all zeros and `bad_size_o` is 0.
- R2: With size code 0, each byte lane i (bits 8i+7..8i) gets the count of leading zeros of that byte, a value from 0 to 8.
- R3: With size code 1, each 16-bit lane gets the count of leading zeros within those 16 bits. Halfword lane e takes predicate bits 2e and 2e+1.
- R4: With size code 2, each 32-bit lane gets the count of leading zeros within those 32 bits. Word lane e takes predicate bits 4e to 4e+3.
- R5: A lane that is all zero gets the lane width as its count: 8, 16 or 32.
- R6: A result byte whose predicate bit is clear keeps the byte of `old_dst_i` at the same position. This holds even when other bytes of the same lane are written.
- R7: Size code 3 sets `bad_size_o` to 1 and makes `dst_o` equal to `old_dst_i`, whatever the predicate.
- R8: For size codes 0, 1 and 2, `bad_size_o` is 0.
- R9: Lane 0 occupies the least significant bits. Each count is zero-extended to the width of its lane, so the upper bytes of a written wide lane are zero.
- R10: `dst_o` and `bad_size_o` show the operands sampled at the previous rising clock edge. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 128 | Source vector whose lanes are counted |
| old_dst_i | input | 128 | Previous destination contents, kept where the predicate is off |
| byte_en_i | input | 16 | Predicate, one bit per byte; bit i guards bits 8i+7..8i |
| size_i | input | 2 | Lane size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| dst_o | output | 128 | Merged destination vector, registered |
| bad_size_o | output | 1 | Registered flag for size code 3 |

## Verification
The assertions assume that the operands are known (not X) at every rising edge after reset, because they compare registered bytes with the operands sampled one edge earlier. The per-lane count checks also assume that the lane value is fully defined before they look at it. The bench meets both assumptions. It drives every operand, always from a defined value, on the falling edge, and it holds reset until those inputs are set. It then draws random vectors with sparse leading bits, random masks, masks that cover only part of a lane, and all four size codes, including the illegal one.

// File: rtl/vlz_pkg.sv
package vlz_pkg;

   typedef enum logic [1:0] {
      LSZ_B8  = 2'd0,
      LSZ_B16 = 2'd1,
      LSZ_B32 = 2'd2,
      LSZ_BAD = 2'd3
   } lane_sz_e;

   localparam int unsigned BYTE_W = 8;

   // number of bytes covered by one lane of the given size code
   function automatic int unsigned lane_bytes(input lane_sz_e sz);
      case (sz)
         LSZ_B8:  return 1;
         LSZ_B16: return 2;
         LSZ_B32: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/vlz_lane_count.sv
module vlz_lane_count #(
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANE_W-1:0] lane_i,
   output logic [LANE_W-1:0] cnt_o
);
   localparam int unsigned CNT_W = $clog2(LANE_W + 1);

   generate
      if (LANE_W < 2 || CNT_W > LANE_W) begin : g_bad_w
         $error("vlz_lane_count: LANE_W too small to hold its own count");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   // Scan upward: the highest set bit is seen last and fixes the count.
   always_comb begin
      cnt = CNT_W'(LANE_W);
      for (int i = 0; i < LANE_W; i++) begin
         if (lane_i[i]) cnt = CNT_W'(LANE_W - 1 - i);
      end
   end

   assign cnt_o = LANE_W'(cnt);

   always_comb begin
      if (!$isunknown(lane_i)) begin
         a_r5_count_range: assert (cnt <= CNT_W'(LANE_W));
         a_r5_zero_full: assert ((lane_i == '0) == (cnt == CNT_W'(LANE_W)));
      end
   end

endmodule

// File: rtl/vlz_width_bank.sv
module vlz_width_bank #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8
) (
   input  logic [VEC_W-1:0] src_i,
   output logic [VEC_W-1:0] cnt_o
);
   localparam int unsigned N_LANES = VEC_W / LANE_W;

   generate
      if (VEC_W % LANE_W != 0) begin : g_bad_split
         $error("vlz_width_bank: VEC_W must be a multiple of LANE_W");
      end
      for (genvar e = 0; e < N_LANES; e++) begin : g_lane
         vlz_lane_count #(.LANE_W(LANE_W)) u_cnt (
            .lane_i (src_i[e*LANE_W +: LANE_W]),
            .cnt_o  (cnt_o[e*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/vlz_byte_merge.sv
module vlz_byte_merge #(
   parameter int unsigned VEC_W = 128
) (
   input  logic [VEC_W-1:0]   res_i,
   input  logic [VEC_W-1:0]   old_i,
   input  logic [VEC_W/8-1:0] en_i,
   output logic [VEC_W-1:0]   merged_o
);
   localparam int unsigned N_BYTES = VEC_W / 8;

   generate
      if (VEC_W % 8 != 0) begin : g_bad_bytes
         $error("vlz_byte_merge: VEC_W must be a whole number of bytes");
      end
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
         assign merged_o[b*8 +: 8] = en_i[b] ? res_i[b*8 +: 8] : old_i[b*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/vlz_pred_unit.sv
module vlz_pred_unit #(
   parameter int unsigned VEC_W = 128,
   localparam int unsigned N_BYTES = VEC_W / 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [VEC_W-1:0]   src_i,
   input  logic [VEC_W-1:0]   old_dst_i,
   input  logic [N_BYTES-1:0] byte_en_i,
   input  logic [1:0]         size_i,
   output logic [VEC_W-1:0]   dst_o,
   output logic               bad_size_o
);
   import vlz_pkg::*;

   generate
      if (VEC_W % 32 != 0 || VEC_W == 0) begin : g_bad_vec
         $error("vlz_pred_unit: VEC_W must be a nonzero multiple of 32");
      end
   endgenerate

   lane_sz_e sz;
   assign sz = lane_sz_e'(size_i);

   logic [VEC_W-1:0] cnt8, cnt16, cnt32;

   vlz_width_bank #(.VEC_W(VEC_W), .LANE_W(8))  u_bank8  (.src_i(src_i), .cnt_o(cnt8));
   vlz_width_bank #(.VEC_W(VEC_W), .LANE_W(16)) u_bank16 (.src_i(src_i), .cnt_o(cnt16));
   vlz_width_bank #(.VEC_W(VEC_W), .LANE_W(32)) u_bank32 (.src_i(src_i), .cnt_o(cnt32));

   logic [VEC_W-1:0]   sel_res;
   logic [N_BYTES-1:0] eff_en;
   logic               bad_d;

   always_comb begin
      sel_res = '0;
      eff_en  = byte_en_i;
      bad_d   = 1'b0;
      case (sz)
         LSZ_B8:  sel_res = cnt8;
         LSZ_B16: sel_res = cnt16;
         LSZ_B32: sel_res = cnt32;
         default: begin
            eff_en = '0;
            bad_d  = 1'b1;
         end
      endcase
   end

   logic [VEC_W-1:0] merged;

   vlz_byte_merge #(.VEC_W(VEC_W)) u_merge (
      .res_i    (sel_res),
      .old_i    (old_dst_i),
      .en_i     (eff_en),
      .merged_o (merged)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dst_o      <= '0;
         bad_size_o <= 1'b0;
      end else begin
         dst_o      <= merged;
         bad_size_o <= bad_d;
      end
   end

   a_r8_flag_tracks_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (bad_size_o == ($past(size_i) == 2'd3)));

   a_r7_bad_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && bad_size_o) |-> (dst_o == $past(old_dst_i)));

   generate
      for (genvar b = 0; b < N_BYTES; b++) begin : g_chk
         a_r6_masked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && !$past(byte_en_i[b]))
               |-> (dst_o[b*8 +: 8] == $past(old_dst_i[b*8 +: 8])));
      end
   endgenerate

endmodule

// File: tb/tb_vlz_pred_unit.sv
`timescale 1ns/1ps
module tb_vlz_pred_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src = '0, old = '0, dst;
   logic [15:0]  en = '0;
   logic [1:0]   sz = '0;
   logic         bad;
   int checks = 0, fails = 0;
   logic [127:0] prev_exp;
   logic         prev_bad;

   always #5 clk = ~clk;

   vlz_pred_unit dut (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .old_dst_i(old),
      .byte_en_i(en), .size_i(sz), .dst_o(dst), .bad_size_o(bad)
   );

   function automatic int clz_ref(input logic [31:0] v, input int w);
      int n = 0;
      for (int i = w - 1; i >= 0; i--) begin
         if (v[i]) break;
         n++;
      end
      return n;
   endfunction

   function automatic logic [127:0] ref_dst(input logic [127:0] s, input logic [127:0] o,
                                            input logic [15:0] m, input logic [1:0] z);
      logic [127:0] res = '0, t, r;
      logic [31:0]  msk, v;
      int lb;
      if (z == 2'd3) return o;
      lb  = 1 << z;
      msk = (lb == 4) ? 32'hffff_ffff : ((32'h1 << (lb * 8)) - 1);
      for (int e = 0; e < 16 / lb; e++) begin
         t = s >> (e * lb * 8);
         v = t[31:0] & msk;
         res = res | (128'(clz_ref(v, lb * 8)) << (e * lb * 8));
      end
      r = o;
      for (int b = 0; b < 16; b++) if (m[b]) r[b*8 +: 8] = res[b*8 +: 8];
      return r;
   endfunction

   task automatic check(input string req, input logic [127:0] exp_d, input logic exp_b);
      checks++;
      if (dst !== exp_d || bad !== exp_b) begin
         fails++;
         $display("FAIL %s: dst=%h bad=%b expected dst=%h bad=%b", req, dst, bad, exp_d, exp_b);
      end
   endtask

   // drive on the falling edge, compare on the next falling edge
   task automatic apply(input string req, input logic [127:0] s, input logic [127:0] o,
                        input logic [15:0] m, input logic [1:0] z);
      @(negedge clk);
      src = s; old = o; en = m; sz = z;
      prev_exp = ref_dst(s, o, m, z);
      prev_bad = (z == 2'd3);
      @(negedge clk);
      check(req, prev_exp, prev_bad);
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
   end

   initial begin
      logic [127:0] rs, ro;
      repeat (3) @(negedge clk);
      check("R1", '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", '0, 1'b0);

      // R2 directed literal: byte0=0x01 -> 7, byte1=0x80 -> 0, byte2=0 -> 8, rest 0xFF -> 0
      apply("R2", {{13{8'hff}}, 8'h00, 8'h80, 8'h01}, '0, 16'hffff, 2'd0);
      check("R2", {{13{8'h00}}, 8'h08, 8'h00, 8'h07}, 1'b0);
      // R3 directed: halfword0=0x0001 -> 15
      apply("R3", {{7{16'hffff}}, 16'h0001}, '0, 16'hffff, 2'd1);
      check("R3", {{7{16'h0000}}, 16'h000f}, 1'b0);
      // R4 and R9: word0=0x00010000 -> 15, word3 zero -> 32, counts zero-extended
      apply("R4", {32'h0, {2{32'hffffffff}}, 32'h0001_0000}, '0, 16'hffff, 2'd2);
      check("R9", {32'd32, 32'd0, 32'd0, 32'd15}, 1'b0);
      // R5 all-zero lanes for each width
      apply("R5", '0, '1, 16'hffff, 2'd0);
      check("R5", {16{8'd8}}, 1'b0);
      apply("R5", '0, '1, 16'hffff, 2'd1);
      check("R5", {8{16'd16}}, 1'b0);
      apply("R5", '0, '1, 16'hffff, 2'd2);
      // R6 partial lane: only low byte of each word enabled, upper bytes keep old
      apply("R6", '0, {4{32'hdead_be00}}, 16'h1111, 2'd2);
      check("R6", {4{32'hdead_be20}}, 1'b0);
      apply("R6", '0, {8{16'hab00}}, 16'haaaa, 2'd1);
      check("R6", {8{16'h0000}}, 1'b0);
      // R7 illegal size
      apply("R7", '1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 16'hffff, 2'd3);
      check("R7", 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 1'b1);
      // R10 latency: new inputs do not show before the next rising edge
      @(negedge clk);
      src = '0; old = '0; en = 16'hffff; sz = 2'd0;
      #1 check("R10", prev_exp, prev_bad);
      @(negedge clk);
      check("R10", {16{8'd8}}, 1'b0);

      // random sweeps: all sizes, sparse bits to reach every count
      for (int z = 0; z < 4; z++) begin
         for (int k = 0; k < 300; k++) begin
            rs = {$urandom, $urandom, $urandom, $urandom};
            ro = {$urandom, $urandom, $urandom, $urandom};
            if (k % 3 == 1) rs = rs >> ($urandom % 128);
            if (k % 3 == 2) rs = rs & {$urandom, $urandom, $urandom, $urandom}
                                    & {$urandom, $urandom, $urandom, $urandom};
            case (z)
               0: apply("R2", rs, ro, 16'($urandom), 2'(z));
               1: apply("R3", rs, ro, 16'($urandom), 2'(z));
               2: apply("R4", rs, ro, 16'($urandom), 2'(z));
               default: apply("R8", rs, ro, 16'($urandom), 2'(z));
            endcase
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule